// File: doc/BRIEF.md
# Writeback Slot Allocator

This block hands out result slots in a short delay line that carries finished instructions toward the commit stage. The delay line is a stack of rows, one row per future cycle. Each row holds a fixed number of writeback slots. On every clock the rows move one place toward the head, and an empty row enters at the tail. The head row is presented to the consumer for exactly one cycle.

A producer offers up to a fixed number of completed instruction tags per cycle. Each tag is placed in the earliest free slot of the window. The search begins at the nearest future cycle and the lowest slot. When a row is full, the search carries on into the next cycle's row instead of stalling the producer. If the whole window is full, the tag is dropped and an overflow flag is raised in the same cycle.

With an empty window, a tag offered in cycle t appears at the head in cycle t+1.

Top module: `wb_slot_alloc`

## Requirements
- R1: While reset is held and on the cycle after it, the head shows no valid slot, head_count is 0 and overflow is low.
- R2: A single tag offered to an empty window appears in head slot 0, with head_count 1, on the next cycle.
- R3: Tags offered in the same cycle are placed in request-index order: a lower index gets an earlier cycle, or a lower slot in the same cycle.
- R4: Once a row's WIDTH slots are taken, further tags spill into the following cycle's row and reach the head one cycle later.
- R5: Slots that are already taken are skipped. A new tag lands in the lowest free slot of the nearest row that has room, and earlier entries keep their slot and tag.
- R6: Every clock all rows advance one place toward the head. A head entry is shown for one cycle only, and the row entering at the tail is empty unless it is written that cycle.
- R7: The head's valid bits form a contiguous run from slot 0 (head_valid bit s is slot s). head_count equals the number of set head_valid bits.
- R8: The window holds WIDTH*DEPTH tags. A tag that finds no free slot is dropped, overflow is high in the cycle it was offered, and no stored entry changes.
- R9: A synchronous active-low reset in mid-run empties every row; the head is empty on the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NREQ | One bit per request lane; bit i qualifies lane i |
| req_tag | input | NREQ*TAG_W | Lane i tag in bits [i*TAG_W +: TAG_W] |
| head_valid | output | WIDTH | Valid bits of the head row, bit s = slot s |
| head_tag | output | WIDTH*TAG_W | Head slot s tag in bits [s*TAG_W +: TAG_W] |
| head_count | output | $clog2(WIDTH+1) | Number of valid head slots |
| overflow | output | 1 | High when a tag offered this cycle found no slot |

## Verification
Allocation and shifting happen in the same clock. A new tag must land in the row that is about to move into a given position, while the previous head row drains away. The bench provokes this by offering a burst wider than one row just as an earlier spilled tag reaches the nearest future row. A scoreboard model shifts its own rows and replays the placement rule, and then judges every head row against it. A sustained burst of three tags per cycle against two drained per cycle fills the window, so that an overflow drop coincides with the shift; the drop is checked in its own cycle and the surviving entries in later cycles.

// File: rtl/wba_pkg.sv
// Shared helpers for the writeback slot allocator.
// Assumes: callers pass positive counts.
package wba_pkg;

    // Width needed to hold a count from 0 to n inclusive.
    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wba_search.sv
// Slot search: places each valid request lane, in lane order, into the
// lowest free flat slot index (offset*WIDTH + slot). A lane that finds no
// free slot is reported as dropped.
// Assumes: occ reflects the window as it will look after this clock's shift.
module wba_search #(
    parameter int NREQ  = 3,
    parameter int NSLOT = 8,
    parameter int TAG_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSLOT-1:0]       occ,
    input  logic [NREQ-1:0]        req_valid,
    input  logic [NREQ*TAG_W-1:0]  req_tag,
    output logic [NSLOT-1:0]       wr_en,
    output logic [NSLOT*TAG_W-1:0] wr_tag,
    output logic [NREQ-1:0]        drop
);

    // Sequential first-free scan across lanes, each lane seeing earlier grants.
    always_comb begin
        logic [NSLOT-1:0] taken;
        logic             found;
        taken  = occ;
        wr_en  = '0;
        wr_tag = '0;
        drop   = '0;
        for (int i = 0; i < NREQ; i++) begin
            found = 1'b0;
            if (req_valid[i]) begin
                for (int j = 0; j < NSLOT; j++) begin
                    if (!found && !taken[j]) begin
                        taken[j] = 1'b1;
                        wr_en[j] = 1'b1;
                        wr_tag[j*TAG_W +: TAG_W] = req_tag[i*TAG_W +: TAG_W];
                        found = 1'b1;
                    end
                end
                drop[i] = !found;
            end
        end
    end

    AST_WRITE_FREE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en & occ) == '0); // R5
    AST_GRANT_OR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_en) + $countones(drop) == $countones(req_valid)); // R3
    AST_DROP_ONLY_WHEN_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        drop != '0 |-> $countones(~occ) < $countones(req_valid)); // R8

endmodule

// File: rtl/wba_rows.sv
// Row store: DEPTH rows of WIDTH slots that shift one place toward the head
// each clock. Flat write index k*WIDTH+s lands in row k after the shift.
// Each row keeps its own occupancy count.
// Assumes: a write never targets a slot that is occupied after the shift.
module wba_rows #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 2,
    parameter int TAG_W = 8,
    localparam int NSLOT = DEPTH * WIDTH,
    localparam int CW    = wba_pkg::cnt_w(WIDTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSLOT-1:0]       wr_en,
    input  logic [NSLOT*TAG_W-1:0] wr_tag,
    output logic [NSLOT-1:0]       occ,
    output logic [WIDTH-1:0]       head_valid,
    output logic [WIDTH*TAG_W-1:0] head_tag,
    output logic [CW-1:0]          head_count
);

    logic [WIDTH-1:0]       vld [DEPTH];
    logic [WIDTH*TAG_W-1:0] tag [DEPTH];
    logic [CW-1:0]          cnt [DEPTH];
    logic [WIDTH-1:0]       src_v [DEPTH];
    logic [WIDTH*TAG_W-1:0] src_t [DEPTH];
    logic [CW-1:0]          src_c [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_src
        if (k < DEPTH - 1) begin : g_mid
            // Row k takes row k+1's contents at the next clock.
            assign src_v[k] = vld[k+1];
            assign src_t[k] = tag[k+1];
            assign src_c[k] = cnt[k+1];
        end else begin : g_tail
            // The tail takes a fresh empty row.
            assign src_v[k] = '0;
            assign src_t[k] = '0;
            assign src_c[k] = '0;
        end
        assign occ[k*WIDTH +: WIDTH] = src_v[k];
    end

    // Shift every row toward the head and merge this cycle's writes.
    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (!rst_n) begin
                vld[k] <= '0;
                tag[k] <= '0;
                cnt[k] <= '0;
            end else begin
                for (int s = 0; s < WIDTH; s++) begin
                    vld[k][s] <= src_v[k][s] | wr_en[k*WIDTH+s];
                    tag[k][s*TAG_W +: TAG_W] <= wr_en[k*WIDTH+s]
                        ? wr_tag[(k*WIDTH+s)*TAG_W +: TAG_W]
                        : src_t[k][s*TAG_W +: TAG_W];
                end
                cnt[k] <= src_c[k] + CW'($countones(wr_en[k*WIDTH +: WIDTH]));
            end
        end
    end

    assign head_valid = vld[0];
    assign head_tag   = tag[0];
    assign head_count = cnt[0];

    AST_HEAD_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt[0]) == $countones(vld[0])); // R7
    AST_HEAD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, vld[0]} + 1'b1) & {1'b0, vld[0]}) == '0); // R7
    AST_TAIL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[(DEPTH-1)*WIDTH +: WIDTH] == '0 |=> vld[DEPTH-1] == '0); // R6

    for (genvar k = 0; k < DEPTH - 1; k++) begin : g_chk
        AST_SHIFT_TOWARD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
            vld[k+1] != '0 |=> (vld[k] & $past(vld[k+1])) == $past(vld[k+1])); // R6
    end

endmodule

// File: rtl/wb_slot_alloc.sv
// Writeback slot allocator top: couples the slot search to the row store.
// Requests are placed against the window as it will stand after this
// clock's shift, so an empty window gives one cycle from offer to head.
// Assumes: requests that find no room may be lost; overflow reports them.
module wb_slot_alloc #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 4,
    parameter int NREQ  = 3,
    parameter int TAG_W = 8,
    localparam int NSLOT = WIDTH * DEPTH,
    localparam int CW    = wba_pkg::cnt_w(WIDTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        req_valid,
    input  logic [NREQ*TAG_W-1:0]  req_tag,
    output logic [WIDTH-1:0]       head_valid,
    output logic [WIDTH*TAG_W-1:0] head_tag,
    output logic [CW-1:0]          head_count,
    output logic                   overflow
);

    logic [NSLOT-1:0]       occ;
    logic [NSLOT-1:0]       wr_en;
    logic [NSLOT*TAG_W-1:0] wr_tag;
    logic [NREQ-1:0]        drop;

    wba_search #(.NREQ(NREQ), .NSLOT(NSLOT), .TAG_W(TAG_W)) i_search (
        .clk(clk), .rst_n(rst_n), .occ(occ),
        .req_valid(req_valid), .req_tag(req_tag),
        .wr_en(wr_en), .wr_tag(wr_tag), .drop(drop)
    );

    wba_rows #(.DEPTH(DEPTH), .WIDTH(WIDTH), .TAG_W(TAG_W)) i_rows (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tag(wr_tag),
        .occ(occ), .head_valid(head_valid), .head_tag(head_tag),
        .head_count(head_count)
    );

    // Any dropped lane raises the flag in its own cycle.
    assign overflow = |drop;

    AST_OVERFLOW_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> req_valid != '0); // R8
    AST_NO_OVERFLOW_WITH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~occ) >= $countones(req_valid) |-> !overflow); // R8

endmodule

// File: tb/test_wb_slot_alloc.sv
`timescale 1ns/1ps
module test_wb_slot_alloc;
    localparam int W = 2, D = 4, NR = 3, TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0]    req_valid = '0;
    logic [NR*TW-1:0] req_tag = '0;
    logic [W-1:0]     head_valid;
    logic [W*TW-1:0]  head_tag;
    logic [1:0]       head_count;
    logic             overflow;

    int checks = 0, errors = 0, ovf_seen = 0;
    bit done = 0;

    typedef struct {
        logic [W-1:0]    v;
        logic [W*TW-1:0] t;
        string           lbl;
    } exp_t;
    exp_t exp_q[$];
    exp_t it;

    logic       mv [D][W];
    logic [7:0] mt [D][W];

    always #4 clk = ~clk;

    wb_slot_alloc #(.WIDTH(W), .DEPTH(D), .NREQ(NR), .TAG_W(TW)) i_wb_slot_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .head_valid(head_valid), .head_tag(head_tag), .head_count(head_count),
        .overflow(overflow)
    );

    task automatic chk(input bit ok, input string lbl, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < D; k++)
            for (int s = 0; s < W; s++) begin
                mv[k][s] = 1'b0;
                mt[k][s] = '0;
            end
    endtask

    // Driver: offers n tags, predicts placement, pushes the expected head.
    task automatic step(input int n, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input string lbl);
        logic       nv [D][W];
        logic [7:0] nt [D][W];
        logic [7:0] tg [NR];
        bit exp_ovf, found;
        exp_t e;
        @(negedge clk);
        tg[0] = a; tg[1] = b; tg[2] = c;
        for (int i = 0; i < NR; i++) req_valid[i] = (i < n);
        req_tag = {c, b, a};
        for (int k = 0; k < D; k++)
            for (int s = 0; s < W; s++) begin
                nv[k][s] = (k < D - 1) ? mv[(k < D - 1) ? k + 1 : k][s] : 1'b0;
                nt[k][s] = (k < D - 1) ? mt[(k < D - 1) ? k + 1 : k][s] : 8'h00;
            end
        exp_ovf = 0;
        for (int i = 0; i < n; i++) begin
            found = 0;
            for (int k = 0; k < D; k++)
                for (int s = 0; s < W; s++)
                    if (!found && !nv[k][s]) begin
                        nv[k][s] = 1'b1;
                        nt[k][s] = tg[i];
                        found = 1;
                    end
            if (!found) exp_ovf = 1;
        end
        #1;
        if (overflow) ovf_seen++;
        chk(overflow == exp_ovf, "R8 overflow flag", overflow, exp_ovf);
        for (int s = 0; s < W; s++) begin
            e.v[s] = nv[0][s];
            e.t[s*TW +: TW] = nv[0][s] ? nt[0][s] : 8'h00;
        end
        e.lbl = lbl;
        exp_q.push_back(e);
        for (int k = 0; k < D; k++)
            for (int s = 0; s < W; s++) begin
                mv[k][s] = nv[k][s];
                mt[k][s] = nt[k][s];
            end
    endtask

    // Monitor: compares the head against the scoreboard once per cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                chk(head_valid == it.v, {it.lbl, " head_valid"}, head_valid, it.v);
                chk(int'(head_count) == $countones(it.v), "R7 head_count",
                    head_count, $countones(it.v));
                for (int s = 0; s < W; s++)
                    if (it.v[s])
                        chk(head_tag[s*TW +: TW] == it.t[s*TW +: TW],
                            {it.lbl, " head_tag"}, head_tag[s*TW +: TW], it.t[s*TW +: TW]);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_sim();
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(head_valid == '0, "R1 head_valid in reset", head_valid, 0);
        chk(head_count == '0, "R1 head_count in reset", head_count, 0);
        chk(overflow == 1'b0, "R1 overflow in reset", overflow, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(head_valid == '0, "R1 head_valid after reset", head_valid, 0);

        step(1, 8'h11, 8'h00, 8'h00, "R2 single tag");
        step(0, 8'hee, 8'hdd, 8'hcc, "R6 head cleared");
        step(3, 8'h21, 8'h22, 8'h23, "R3 lane order");
        step(1, 8'h31, 8'h00, 8'h00, "R4 R5 spill and skip");
        step(0, 8'h00, 8'h00, 8'h00, "R6 drain");
        step(2, 8'h41, 8'h42, 8'h00, "R3 two lanes");
        step(0, 8'h00, 8'h00, 8'h00, "R6 drain");

        // Sustained burst: three in, two out per cycle, until the window fills.
        for (int r = 0; r < 8; r++)
            step(3, 8'h50 + 8'(3*r), 8'h51 + 8'(3*r), 8'h52 + 8'(3*r), "R8 burst");
        for (int r = 0; r < 5; r++)
            step(0, 8'h00, 8'h00, 8'h00, "R6 R8 drain after overflow");
        chk(ovf_seen > 0, "R8 overflow observed", ovf_seen, 1);

        // Reset in mid-run.
        step(3, 8'h91, 8'h92, 8'h93, "R3 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = '0;
        @(negedge clk);
        chk(head_valid == '0, "R9 head_valid after mid reset", head_valid, 0);
        chk(head_count == '0, "R9 head_count after mid reset", head_count, 0);
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
        chk(head_valid == '0, "R9 head stays empty", head_valid, 0);

        step(1, 8'ha1, 8'h00, 8'h00, "R2 after reset");
        step(3, 8'hb1, 8'hb2, 8'hb3, "R3 after reset");
        step(0, 8'h00, 8'h00, 8'h00, "R4 spilled tag");
        step(0, 8'h00, 8'h00, 8'h00, "R6 empty");
        @(negedge clk);
        @(negedge clk);
        finish_sim();
    end
endmodule